// File: doc/BRIEF.md
# PS/2 Mouse Packet Receiver

This block listens to a pointing device on its two open-collector wires, a slow clock and a data line, and turns the serial traffic into decoded movement reports in the system clock domain. Each wire first passes through a two-stage synchroniser and a stability filter. Data is captured on every filtered falling edge of the device clock. Every 11-bit frame is checked for its start bit, its odd parity and its stop bit.

Good bytes are grouped three at a time into one report. The block then presents the two button states, signed 9-bit X and Y movement and the two overflow flags. These outputs are updated together with a one-cycle report strobe. A bad frame raises a one-cycle error pulse, and the byte is dropped. A header byte whose always-one bit is clear is skipped so that the byte grouping can realign. A frame left half-finished, with the device clock stuck high, is abandoned after a timeout.

Top module: `ps2m_receiver`

## Requirements
- R1: A pulse on either wire that is shorter than FILT_LEN system cycles after synchronisation is ignored. A clock glitch of that kind inside a frame does not disturb the decoded report and raises no error.
- R2: A frame is start, eight data bits least significant first, parity, stop. A falling edge seen in idle while data is 1 does not begin a frame.
- R3: The eight data bits plus the parity bit must hold an odd number of ones. On a mismatch, err_o pulses for one cycle and the byte is discarded.
- R4: A stop bit that reads 0 makes err_o pulse for one cycle, and the byte is discarded.
- R5: Three good bytes make one report, marked by rpt_vld_o high for exactly one cycle. In header byte 0, bit0 is the left button, bit1 the right button, bit3 is always 1, bit4 is the X sign, bit5 the Y sign, bit6 the X overflow and bit7 the Y overflow (1 = pressed, negative or overflowed). Byte 1 is X[7:0] and byte 2 is Y[7:0].
- R6: dx_o = {X sign, byte 1} and dy_o = {Y sign, byte 2} as 9-bit two's complement, with positive meaning right or up. All report outputs hold their value between strobes.
- R7: A byte expected as header whose bit3 is 0 is discarded, and the following byte is taken as the header. No error is raised.
- R8: A frame error returns the byte grouping to the header position. This also holds when the bad frame would have completed a report.
- R9: If the device clock stays high for TMO_CYC system cycles in the middle of a frame, the partial frame is dropped without an error, and the next frame is received normally.
- R10: After reset, all report outputs, rpt_vld_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_clk_i | input | 1 | Device clock wire, asynchronous |
| ms_dat_i | input | 1 | Device data wire, asynchronous |
| btn_l_o | output | 1 | Left button pressed |
| btn_r_o | output | 1 | Right button pressed |
| dx_o | output | 9 | Signed X movement |
| dy_o | output | 9 | Signed Y movement |
| ovf_x_o | output | 1 | X overflow |
| ovf_y_o | output | 1 | Y overflow |
| rpt_vld_o | output | 1 | One-cycle strobe, new report on outputs |
| err_o | output | 1 | One-cycle pulse on parity or stop-bit error |

## Verification
Two events can meet on the same byte event: a frame error arriving while the grouping sits at the last byte position, where a good byte would have issued a report in that cycle. The bench sends a header and an X byte, then a Y frame with bad parity. The test passes only if err_o pulses, no report strobe appears, and a fresh three-byte report that follows decodes exactly as computed by the bench. Randomised reports, glitches, spurious edges, skipped headers and abandoned frames are also sent, each judged by strobe and error counts and by the decoded fields.

// File: rtl/ps2m_pkg.sv
// Shared constants for the mouse packet receiver.
// Assumes the three-byte report format listed in the brief.
package ps2m_pkg;
    localparam int BYTE_W        = 8;
    localparam int MOV_W         = BYTE_W + 1;
    localparam int BYTES_PER_RPT = 3;
    localparam int POS_W         = $clog2(BYTES_PER_RPT);
    // header byte field positions (decoded by the report assembler)
    localparam int HB_LEFT  = 0;
    localparam int HB_RIGHT = 1;
    localparam int HB_SYNC  = 3;
    localparam int HB_XSIGN = 4;
    localparam int HB_YSIGN = 5;
    localparam int HB_XOVF  = 6;
    localparam int HB_YOVF  = 7;
    typedef enum logic {FR_IDLE = 1'b0, FR_RECV = 1'b1} fr_state_t;
endpackage

// File: rtl/ps2m_line_filter.sv
// Two-stage synchroniser followed by a stability filter.
// The output follows the input only after FILT_LEN consecutive
// differing samples. Assumes FILT_LEN >= 2.
module ps2m_line_filter #(
    parameter int   FILT_LEN = 8,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // bring the asynchronous wire into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {2{RST_VAL}};
        else        sync_q <= {sync_q[0], raw_i};
    end

    // accept a new level only once it has been stable long enough
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_o <= RST_VAL;
        end else if (sync_q[1] == filt_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            filt_o <= sync_q[1];
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_FILT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_o) |-> ($past(sync_q[1]) == filt_o && $past(sync_q[1], 2) == filt_o)); // R1
endmodule

// File: rtl/ps2m_frame_rx.sv
// Frame receiver: samples data on each falling edge of the filtered
// device clock and checks the start bit, odd parity and stop bit.
// It drops a partial frame once the clock has stayed high for TMO_CYC
// cycles. Assumes both inputs are already synchronised and filtered.
module ps2m_frame_rx
    import ps2m_pkg::*;
#(
    parameter int TMO_CYC = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ps_clk_i,
    input  logic              ps_dat_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              frm_err_o
);
    localparam int TW = $clog2(TMO_CYC + 1);

    fr_state_t         st_q;
    logic              clk_d_q;
    logic [3:0]        bit_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              par_q;
    logic [TW-1:0]     tmo_q;
    logic              fall;
    logic              par_ok;

    assign fall   = clk_d_q & ~ps_clk_i;
    assign par_ok = ^{shreg_q, par_q};
    assign byte_o = shreg_q;

    // bit sequencing, frame checks and the stuck-high timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d_q    <= 1'b1;
            st_q       <= FR_IDLE;
            bit_q      <= '0;
            shreg_q    <= '0;
            par_q      <= 1'b0;
            tmo_q      <= '0;
            byte_vld_o <= 1'b0;
            frm_err_o  <= 1'b0;
        end else begin
            clk_d_q    <= ps_clk_i;
            byte_vld_o <= 1'b0;
            frm_err_o  <= 1'b0;
            if (st_q == FR_IDLE) begin
                tmo_q <= '0;
                if (fall && !ps_dat_i) begin
                    st_q  <= FR_RECV;
                    bit_q <= '0;
                end
            end else if (fall) begin
                tmo_q <= '0;
                if (bit_q < 4'd8) begin
                    shreg_q <= {ps_dat_i, shreg_q[BYTE_W-1:1]};
                    bit_q   <= bit_q + 1'b1;
                end else if (bit_q == 4'd8) begin
                    par_q <= ps_dat_i;
                    bit_q <= bit_q + 1'b1;
                end else begin
                    byte_vld_o <= par_ok & ps_dat_i;
                    frm_err_o  <= ~(par_ok & ps_dat_i);
                    st_q       <= FR_IDLE;
                end
            end else if (ps_clk_i) begin
                if (tmo_q == TW'(TMO_CYC - 1)) st_q <= FR_IDLE;
                else                          tmo_q <= tmo_q + 1'b1;
            end
        end
    end

    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_o || frm_err_o) |=> !(byte_vld_o || frm_err_o)); // R2
endmodule

// File: rtl/ps2m_report_asm.sv
// Report assembler: groups good bytes into three-byte reports and
// decodes the buttons, signed movement and overflow flags. Assumes at
// most one byte event per cycle and that a frame error is never
// flagged together with a good byte.
module ps2m_report_asm
    import ps2m_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              byte_vld_i,
    input  logic              frm_err_i,
    output logic              btn_l_o,
    output logic              btn_r_o,
    output logic [MOV_W-1:0]  dx_o,
    output logic [MOV_W-1:0]  dy_o,
    output logic              ovf_x_o,
    output logic              ovf_y_o,
    output logic              rpt_vld_o
);
    logic [POS_W-1:0]  pos_q;
    logic [BYTE_W-1:0] hdr_q;
    logic [BYTE_W-1:0] xb_q;

    // byte position tracking, header realignment and report issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q     <= '0;
            hdr_q     <= '0;
            xb_q      <= '0;
            btn_l_o   <= 1'b0;
            btn_r_o   <= 1'b0;
            dx_o      <= '0;
            dy_o      <= '0;
            ovf_x_o   <= 1'b0;
            ovf_y_o   <= 1'b0;
            rpt_vld_o <= 1'b0;
        end else begin
            rpt_vld_o <= 1'b0;
            if (frm_err_i) begin
                pos_q <= '0;
            end else if (byte_vld_i) begin
                case (pos_q)
                    POS_W'(0): begin
                        if (byte_i[HB_SYNC]) begin
                            hdr_q <= byte_i;
                            pos_q <= POS_W'(1);
                        end
                    end
                    POS_W'(1): begin
                        xb_q  <= byte_i;
                        pos_q <= POS_W'(2);
                    end
                    default: begin
                        btn_l_o   <= hdr_q[HB_LEFT];
                        btn_r_o   <= hdr_q[HB_RIGHT];
                        ovf_x_o   <= hdr_q[HB_XOVF];
                        ovf_y_o   <= hdr_q[HB_YOVF];
                        dx_o      <= {hdr_q[HB_XSIGN], xb_q};
                        dy_o      <= {hdr_q[HB_YSIGN], byte_i};
                        rpt_vld_o <= 1'b1;
                        pos_q     <= '0;
                    end
                endcase
            end
        end
    end

    AST_RPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld_o |=> !rpt_vld_o); // R5
    AST_RPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_vld_o |-> ($stable(dx_o) && $stable(dy_o) && $stable(btn_l_o) && $stable(ovf_y_o))); // R6
    AST_HDR_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !frm_err_i && pos_q == '0 && !byte_i[HB_SYNC]) |=> pos_q == '0); // R7
    AST_ERR_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err_i |=> (pos_q == '0 && !rpt_vld_o)); // R8
endmodule

// File: rtl/ps2m_receiver.sv
// Top level of the mouse packet receiver: filters both wires, receives
// frames and assembles decoded reports. Assumes the device clock is far
// slower than the system clock (FILT_LEN plus a few cycles per half period).
module ps2m_receiver
    import ps2m_pkg::*;
#(
    parameter int FILT_LEN = 8,
    parameter int TMO_CYC  = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_clk_i,
    input  logic             ms_dat_i,
    output logic             btn_l_o,
    output logic             btn_r_o,
    output logic [MOV_W-1:0] dx_o,
    output logic [MOV_W-1:0] dy_o,
    output logic             ovf_x_o,
    output logic             ovf_y_o,
    output logic             rpt_vld_o,
    output logic             err_o
);
    logic              clk_f, dat_f;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_vld, rx_err;

    ps2m_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_clk_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(ms_clk_i), .filt_o(clk_f));
    ps2m_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_dat_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(ms_dat_i), .filt_o(dat_f));

    ps2m_frame_rx #(.TMO_CYC(TMO_CYC)) u_frame (
        .clk(clk), .rst_n(rst_n), .ps_clk_i(clk_f), .ps_dat_i(dat_f),
        .byte_o(rx_byte), .byte_vld_o(rx_vld), .frm_err_o(rx_err));

    ps2m_report_asm u_asm (
        .clk(clk), .rst_n(rst_n), .byte_i(rx_byte), .byte_vld_i(rx_vld),
        .frm_err_i(rx_err), .btn_l_o(btn_l_o), .btn_r_o(btn_r_o),
        .dx_o(dx_o), .dy_o(dy_o), .ovf_x_o(ovf_x_o), .ovf_y_o(ovf_y_o),
        .rpt_vld_o(rpt_vld_o));

    assign err_o = rx_err;

    AST_ERR_NOT_RPT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !rpt_vld_o); // R3
endmodule

// File: tb/ps2m_receiver_tb_top.sv
// Bench: randomised reports plus directed corner cases, checked against
// values computed from the requirements.
module ps2m_receiver_tb_top;
    localparam int FILT = 3;
    localparam int TMO  = 60;
    localparam int H    = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_clk = 1'b1;
    logic       ms_dat = 1'b1;
    logic       btn_l, btn_r, ovf_x, ovf_y, rpt_vld, err;
    logic [8:0] dx, dy;

    int total = 0;
    int bad = 0;
    int rpt_cnt = 0;
    int err_cnt = 0;
    int hold_bad = 0;
    bit done = 1'b0;
    logic [8:0] cap_dx, cap_dy;
    logic cap_l, cap_r, cap_ox, cap_oy;

    always #4 clk = ~clk;

    ps2m_receiver #(.FILT_LEN(FILT), .TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .ms_clk_i(ms_clk), .ms_dat_i(ms_dat),
        .btn_l_o(btn_l), .btn_r_o(btn_r), .dx_o(dx), .dy_o(dy),
        .ovf_x_o(ovf_x), .ovf_y_o(ovf_y), .rpt_vld_o(rpt_vld), .err_o(err));

    // observe strobes and errors away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rpt_vld) begin
                rpt_cnt++;
                cap_dx = dx; cap_dy = dy; cap_l = btn_l; cap_r = btn_r;
                cap_ox = ovf_x; cap_oy = ovf_y;
            end else if (rpt_cnt > 0 && (dx !== cap_dx || dy !== cap_dy ||
                         btn_l !== cap_l || btn_r !== cap_r ||
                         ovf_x !== cap_ox || ovf_y !== cap_oy)) begin
                hold_bad++;
            end
            if (err) err_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_mov(input logic s, input logic [7:0] m);
        return {s, m};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        ms_dat = b;
        if (glitch) begin
            wait_cyc(4); ms_clk = 1'b0; wait_cyc(2); ms_clk = 1'b1; wait_cyc(H - 6);
        end else begin
            wait_cyc(H);
        end
        ms_clk = 1'b0;
        wait_cyc(H);
        ms_clk = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par,
                              input bit bad_stop, input bit glitch);
        send_bit(1'b0, glitch);
        for (int i = 0; i < 8; i++) send_bit(b[i], glitch);
        send_bit((~^b) ^ bad_par, glitch);
        send_bit(~bad_stop, glitch);
        ms_dat = 1'b1;
        wait_cyc(2 * H);
    endtask

    task automatic send_report(input logic [7:0] b0, b1, b2, input bit glitch);
        send_frame(b0, 0, 0, glitch);
        send_frame(b1, 0, 0, glitch);
        send_frame(b2, 0, 0, glitch);
        wait_cyc(10);
    endtask

    task automatic check_report(input string req, input logic [7:0] b0, b1, b2,
                                input int rc0, input int ec0);
        chk({req, " strobe count"}, rpt_cnt, rc0 + 1);
        chk({req, " error count"}, err_cnt, ec0);
        chk({req, " buttons"}, {30'd0, btn_r, btn_l}, {30'd0, b0[1], b0[0]});
        chk({req, " dx"}, int'(dx), int'(exp_mov(b0[4], b1)));
        chk({req, " dy"}, int'(dy), int'(exp_mov(b0[5], b2)));
        chk({req, " overflow"}, {30'd0, ovf_y, ovf_x}, {30'd0, b0[7], b0[6]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b0, b1, b2;
        int rc, ec;
        void'($urandom(32'd1234));
        wait_cyc(5);
        // R10: reset state
        chk("R10 report outputs", int'({dx, dy, btn_l, btn_r, ovf_x, ovf_y}), 0);
        chk("R10 strobes", int'({rpt_vld, err}), 0);
        rst_n = 1'b1;
        wait_cyc(5);

        // R5 R6: directed sign and overflow corners
        rc = rpt_cnt; ec = err_cnt;
        send_report(8'hF9, 8'h00, 8'hFF, 0);
        check_report("R5 R6 all-flags", 8'hF9, 8'h00, 8'hFF, rc, ec);
        chk("R6 negative dx value", int'($signed(dx)), -256);
        rc = rpt_cnt;
        send_report(8'h0A, 8'h7F, 8'h01, 0);
        check_report("R5 R6 right-up", 8'h0A, 8'h7F, 8'h01, rc, ec);

        // R5 R6: random reports
        for (int n = 0; n < 16; n++) begin
            b0 = 8'($urandom) | 8'h08; b1 = 8'($urandom); b2 = 8'($urandom);
            rc = rpt_cnt; ec = err_cnt;
            send_report(b0, b1, b2, 0);
            check_report("R5 R6 random", b0, b1, b2, rc, ec);
        end

        // R1: clock glitches inside every bit
        b0 = 8'h29; b1 = 8'hC3; b2 = 8'h5A;
        rc = rpt_cnt; ec = err_cnt;
        send_report(b0, b1, b2, 1);
        check_report("R1 glitch", b0, b1, b2, rc, ec);

        // R2: spurious falling edge with data high in idle
        rc = rpt_cnt; ec = err_cnt;
        ms_dat = 1'b1; ms_clk = 1'b0; wait_cyc(H); ms_clk = 1'b1; wait_cyc(2 * H);
        send_report(8'h19, 8'h33, 8'h80, 0);
        check_report("R2 start must be 0", 8'h19, 8'h33, 8'h80, rc, ec);

        // R3 + R8: bad parity on the X byte
        rc = rpt_cnt; ec = err_cnt;
        send_frame(8'h09, 0, 0, 0);
        send_frame(8'h44, 1, 0, 0);
        wait_cyc(10);
        chk("R3 parity error pulse", err_cnt, ec + 1);
        chk("R3 no report", rpt_cnt, rc);
        send_report(8'h0B, 8'h12, 8'h34, 0);
        check_report("R3 R8 after parity error", 8'h0B, 8'h12, 8'h34, rc, ec + 1);

        // R8: bad frame where the report would complete
        rc = rpt_cnt; ec = err_cnt;
        send_frame(8'h18, 0, 0, 0);
        send_frame(8'h21, 0, 0, 0);
        send_frame(8'h77, 1, 0, 0);
        wait_cyc(10);
        chk("R8 error at last byte", err_cnt, ec + 1);
        chk("R8 no report at last byte", rpt_cnt, rc);
        send_report(8'h0D, 8'hAA, 8'h55, 0);
        check_report("R8 realigned", 8'h0D, 8'hAA, 8'h55, rc, ec + 1);

        // R4: bad stop bit
        rc = rpt_cnt; ec = err_cnt;
        send_frame(8'h08, 0, 1, 0);
        wait_cyc(10);
        chk("R4 stop error pulse", err_cnt, ec + 1);
        send_report(8'h0E, 8'h01, 8'h02, 0);
        check_report("R4 after stop error", 8'h0E, 8'h01, 8'h02, rc, ec + 1);

        // R7: header without its always-one bit is skipped
        rc = rpt_cnt; ec = err_cnt;
        send_frame(8'hF7, 0, 0, 0);
        send_report(8'h3C, 8'h90, 8'h0F, 0);
        check_report("R7 header skip", 8'h3C, 8'h90, 8'h0F, rc, ec);

        // R9: partial frame abandoned by the timeout
        rc = rpt_cnt; ec = err_cnt;
        send_bit(1'b0, 0); send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
        ms_dat = 1'b1;
        wait_cyc(TMO + 40);
        send_report(8'h1A, 8'h66, 8'h99, 0);
        check_report("R9 timeout", 8'h1A, 8'h66, 8'h99, rc, ec);

        chk("R6 outputs held between strobes", hold_bad, 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule